// File: doc/BRIEF.md
# Three-Phase abc to dq Transform

This block maps a three-phase set of signed samples (phase voltages or phase currents) onto the rotating direct and quadrature axes of a grid-synchronous frame. It takes the sine and cosine of the present grid angle from a phase tracker and needs no other trigonometric values. The angle-shifted terms of the transform come from those two values through fixed weights: minus one half, taken as an arithmetic right shift, and a fixed-point root-three-over-two constant. The zero-sequence part is not computed, because the three-phase system is taken to be balanced.

One pulse on `start_i` hands the block a job with two channel sets: a voltage set and a current set, both rotated by the same angle. A small sequencer latches both sets and the angle. It then feeds them one after the other into a single pipelined datapath. Each set comes out with a one-cycle `done_o` pulse, `chan_o` tells which set it is, and the d and q results are clipped to the sample width.

Top module: `abcdq_xform`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0, and `d_o` and `q_o` are 0 until the first result is delivered.
- R2: From s = `sin_i` and c = `cos_i` (signed Q1.15) and K3 = 28378, the block forms these weights: hc = c>>>1, hs = s>>>1, ks = (K3*s)>>>15 and kc = (K3*c)>>>15, where >>> is an arithmetic shift that rounds toward minus infinity. The d-axis weights for phases a, b, c are c, -hc+ks and -hc-ks. The q-axis weights are s, -hs-kc and -hs+kc.
- R3: `d_o` = clip(((Sd>>>15)*26755)>>>15), where Sd is the exact sum over the three phases of the signed sample times its d-axis weight.
- R4: `q_o` = clip(((Sq>>>15)*26755)>>>15), with Sq formed in the same way from the q-axis weights.
- R5: clip limits a result to the range -32768 to 32767. A value above the range gives 32767 and a value below it gives -32768.
- R6: A start that is accepted in cycle t gives exactly two `done_o` pulses. The first is in cycle t+6 with `chan_o`=0 and carries the voltage set (`vlt_*`). The second is in cycle t+7 with `chan_o`=1 and carries the current set (`cur_*`).
- R7: The phase and angle inputs are sampled only in the cycle a start is accepted. Changes to them afterwards do not affect that job's results.
- R8: A start asserted in cycle t+1 or t+2 after an accepted start is ignored. A start in cycle t+3 is accepted and gives its own pair of results at t+9 and t+10.
- R9: `d_o` and `q_o` hold their last delivered values in every cycle without a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job request; accepted when the sequencer is idle |
| sin_i | input | 16 | Sine of grid angle, signed Q1.15 |
| cos_i | input | 16 | Cosine of grid angle, signed Q1.15 |
| vlt_a_i | input | 16 | Voltage set, phase a, signed |
| vlt_b_i | input | 16 | Voltage set, phase b, signed |
| vlt_c_i | input | 16 | Voltage set, phase c, signed |
| cur_a_i | input | 16 | Current set, phase a, signed |
| cur_b_i | input | 16 | Current set, phase b, signed |
| cur_c_i | input | 16 | Current set, phase c, signed |
| done_o | output | 1 | One-cycle pulse when a set's result is on d_o/q_o |
| chan_o | output | 1 | Set tag of the result: 0 voltage, 1 current |
| d_o | output | 16 | Direct-axis result, signed, clipped |
| q_o | output | 16 | Quadrature-axis result, signed, clipped |

## Verification
The assertions assume that `start_i` is synchronous to `clk`. They also assume that an accepted job is never cut short except by reset, so every first-set result has a matching second-set result one cycle later, exactly six cycles after acceptance. The bench changes inputs only on falling edges. It keeps the angle inputs on a rounded unit circle, except for the full-scale cases that are meant to drive the clip. On purpose, it repeats start and changes the sample inputs while a job is being issued, which exercises the ignore and capture rules within those assumptions.

// File: rtl/abcdq_pkg.sv
package abcdq_pkg;
    localparam int NUM_PH = 3;
    localparam int NUM_AX = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SET0 = 2'd1,
        SEQ_SET1 = 2'd2
    } seq_st_e;
endpackage

// File: rtl/abcdq_job_seq.sv
module abcdq_job_seq
    import abcdq_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [TW-1:0]                sin_i,
    input  logic [TW-1:0]                cos_i,
    input  logic [NUM_PH-1:0][DW-1:0]    set0_i,
    input  logic [NUM_PH-1:0][DW-1:0]    set1_i,
    output logic                         acc_o,
    output logic                         iss_vld_o,
    output logic                         iss_tag_o,
    output logic [NUM_PH-1:0][DW-1:0]    iss_ph_o,
    output logic [TW-1:0]                iss_sin_o,
    output logic [TW-1:0]                iss_cos_o
);
    typedef struct packed {
        seq_st_e                      st;
        logic [NUM_PH-1:0][DW-1:0]    s0;
        logic [NUM_PH-1:0][DW-1:0]    s1;
        logic [TW-1:0]                sn;
        logic [TW-1:0]                cs;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        acc_o = 1'b0;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    acc_o  = 1'b1;
                    r_d.st = SEQ_SET0;
                    r_d.s0 = set0_i;
                    r_d.s1 = set1_i;
                    r_d.sn = sin_i;
                    r_d.cs = cos_i;
                end
            end
            SEQ_SET0: r_d.st = SEQ_SET1;
            SEQ_SET1: r_d.st = SEQ_IDLE;
            default:  r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign iss_vld_o = (r_q.st != SEQ_IDLE);
    assign iss_tag_o = (r_q.st == SEQ_SET1);
    assign iss_ph_o  = (r_q.st == SEQ_SET1) ? r_q.s1 : r_q.s0;
    assign iss_sin_o = r_q.sn;
    assign iss_cos_o = r_q.cs;

    // R8: the second set is always issued right after the first
    a_r8_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SEQ_SET0) |=> (r_q.st == SEQ_SET1));

    // R7: captured job data cannot change while a job is being issued
    a_r7_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != SEQ_IDLE) |=> ($stable(r_q.s0) && $stable(r_q.s1)
                                  && $stable(r_q.sn) && $stable(r_q.cs)));
endmodule

// File: rtl/abcdq_coef_gen.sv
module abcdq_coef_gen
    import abcdq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TW      = 16,
    parameter int FRAC    = 15,
    parameter int CW      = TW + 2,
    parameter int K_SQ3H  = 28378
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   vld_i,
    input  logic                                   tag_i,
    input  logic [NUM_PH-1:0][DW-1:0]              ph_i,
    input  logic [TW-1:0]                          sin_i,
    input  logic [TW-1:0]                          cos_i,
    output logic                                   vld_o,
    output logic                                   tag_o,
    output logic [NUM_PH-1:0][DW-1:0]              ph_o,
    output logic [NUM_AX-1:0][NUM_PH-1:0][CW-1:0]  w_o
);
    localparam int KW = TW + 2;
    localparam int PW = TW + KW;
    localparam logic signed [KW-1:0] KC = KW'(K_SQ3H);

    typedef struct packed {
        logic                                  vld;
        logic                                  tag;
        logic [NUM_PH-1:0][DW-1:0]             ph;
        logic [NUM_AX-1:0][NUM_PH-1:0][CW-1:0] w;
    } cg_t;

    cg_t c_d, c_q;

    logic signed [TW-1:0] sn, cs;
    logic signed [PW-1:0] ps, pc;
    logic signed [CW-1:0] se, ce, hs, hc, ks, kc;
    logic                 unused_prod;

    always_comb begin
        sn = $signed(sin_i);
        cs = $signed(cos_i);
        ps = PW'(sn) * PW'(KC);
        pc = PW'(cs) * PW'(KC);
        ks = ps[FRAC +: CW];
        kc = pc[FRAC +: CW];
        se = CW'(sn);
        ce = CW'(cs);
        hs = se >>> 1;
        hc = ce >>> 1;

        c_d        = c_q;
        c_d.vld    = vld_i;
        c_d.tag    = tag_i;
        c_d.ph     = ph_i;
        c_d.w[0][0] = ce;
        c_d.w[0][1] = -hc + ks;
        c_d.w[0][2] = -hc - ks;
        c_d.w[1][0] = se;
        c_d.w[1][1] = -hs - kc;
        c_d.w[1][2] = -hs + kc;
    end

    assign unused_prod = ^{ps[FRAC-1:0], pc[FRAC-1:0], ps[PW-1:FRAC+CW], pc[PW-1:FRAC+CW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign vld_o = c_q.vld;
    assign tag_o = c_q.tag;
    assign ph_o  = c_q.ph;
    assign w_o   = c_q.w;

    // R6: a second-set entry is always preceded by a first-set entry
    a_r6_coef_order: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.vld && c_q.tag) |-> $past(c_q.vld && !c_q.tag));
endmodule

// File: rtl/abcdq_mac.sv
module abcdq_mac
    import abcdq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CW     = 18,
    parameter int FRAC   = 15,
    parameter int K_NORM = 26755
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   vld_i,
    input  logic                                   tag_i,
    input  logic [NUM_PH-1:0][DW-1:0]              ph_i,
    input  logic [NUM_AX-1:0][NUM_PH-1:0][CW-1:0]  w_i,
    output logic                                   vld_o,
    output logic                                   tag_o,
    output logic [NUM_AX-1:0][DW-1:0]              res_o
);
    localparam int PW    = DW + CW;
    localparam int SW    = PW + 2;
    localparam int RW    = SW - FRAC;
    localparam int KW    = DW + 1;
    localparam int MW    = RW + KW;
    localparam int OW    = MW - FRAC;
    localparam int DEPTH = 4;
    localparam logic signed [KW-1:0] KN = KW'(K_NORM);
    localparam logic signed [OW-1:0] HI = OW'((2 ** (DW - 1)) - 1);
    localparam logic signed [OW-1:0] LO = OW'(-(2 ** (DW - 1)));

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] tag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = {ctl_q.vld[DEPTH-2:0], vld_i};
        ctl_d.tag = {ctl_q.tag[DEPTH-2:0], tag_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign vld_o = ctl_q.vld[DEPTH-1];
    assign tag_o = ctl_q.tag[DEPTH-1];

    for (genvar ax = 0; ax < NUM_AX; ax++) begin : g_axis
        typedef struct packed {
            logic [NUM_PH-1:0][PW-1:0] prod;
            logic [RW-1:0]             sum;
            logic [MW-1:0]             scl;
            logic [DW-1:0]             res;
        } ax_t;

        ax_t a_d, a_q;
        logic signed [SW-1:0] tot;
        logic signed [MW-1:0] mul;
        logic signed [OW-1:0] shr;
        logic                 unused_low;

        always_comb begin
            a_d = a_q;
            for (int p = 0; p < NUM_PH; p++) begin
                a_d.prod[p] = PW'($signed(ph_i[p])) * PW'($signed(w_i[ax][p]));
            end
            tot = SW'($signed(a_q.prod[0])) + SW'($signed(a_q.prod[1]))
                + SW'($signed(a_q.prod[2]));
            a_d.sum = tot[FRAC +: RW];
            mul     = MW'($signed(a_q.sum)) * MW'(KN);
            a_d.scl = mul;
            shr     = $signed(a_q.scl[MW-1:FRAC]);
            if (ctl_q.vld[DEPTH-2]) begin
                if (shr > HI)      a_d.res = HI[DW-1:0];
                else if (shr < LO) a_d.res = LO[DW-1:0];
                else               a_d.res = shr[DW-1:0];
            end
        end

        assign unused_low = ^{tot[FRAC-1:0], a_q.scl[FRAC-1:0]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) a_q <= '0;
            else        a_q <= a_d;
        end

        assign res_o[ax] = a_q.res;
    end

    // R6: results leave in set order, second set right after the first
    a_r6_out_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.vld[DEPTH-1] && ctl_q.tag[DEPTH-1])
        |-> $past(ctl_q.vld[DEPTH-1] && !ctl_q.tag[DEPTH-1]));
endmodule

// File: rtl/abcdq_xform.sv
module abcdq_xform
    import abcdq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TW      = 16,
    parameter int FRAC    = 15,
    parameter int K_SQ3H  = 28378,
    parameter int K_NORM  = 26755
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] sin_i,
    input  logic [TW-1:0] cos_i,
    input  logic [DW-1:0] vlt_a_i,
    input  logic [DW-1:0] vlt_b_i,
    input  logic [DW-1:0] vlt_c_i,
    input  logic [DW-1:0] cur_a_i,
    input  logic [DW-1:0] cur_b_i,
    input  logic [DW-1:0] cur_c_i,
    output logic          done_o,
    output logic          chan_o,
    output logic [DW-1:0] d_o,
    output logic [DW-1:0] q_o
);
    localparam int CW = TW + 2;

    logic                                  seq_acc, seq_vld, seq_tag;
    logic [NUM_PH-1:0][DW-1:0]             seq_ph, cg_ph;
    logic [TW-1:0]                         seq_sin, seq_cos;
    logic                                  cg_vld, cg_tag;
    logic [NUM_AX-1:0][NUM_PH-1:0][CW-1:0] cg_w;
    logic [NUM_AX-1:0][DW-1:0]             mac_res;

    abcdq_job_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sin_i     (sin_i),
        .cos_i     (cos_i),
        .set0_i    ({vlt_c_i, vlt_b_i, vlt_a_i}),
        .set1_i    ({cur_c_i, cur_b_i, cur_a_i}),
        .acc_o     (seq_acc),
        .iss_vld_o (seq_vld),
        .iss_tag_o (seq_tag),
        .iss_ph_o  (seq_ph),
        .iss_sin_o (seq_sin),
        .iss_cos_o (seq_cos)
    );

    abcdq_coef_gen #(.DW(DW), .TW(TW), .FRAC(FRAC), .CW(CW), .K_SQ3H(K_SQ3H)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (seq_vld),
        .tag_i (seq_tag),
        .ph_i  (seq_ph),
        .sin_i (seq_sin),
        .cos_i (seq_cos),
        .vld_o (cg_vld),
        .tag_o (cg_tag),
        .ph_o  (cg_ph),
        .w_o   (cg_w)
    );

    abcdq_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .K_NORM(K_NORM)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (cg_vld),
        .tag_i (cg_tag),
        .ph_i  (cg_ph),
        .w_i   (cg_w),
        .vld_o (done_o),
        .tag_o (chan_o),
        .res_o (mac_res)
    );

    assign d_o = mac_res[0];
    assign q_o = mac_res[1];

    // R6: every voltage-set result is followed by the current-set result
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !chan_o) |=> (done_o && chan_o));

    // R6: a voltage-set result appears six cycles after acceptance
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !chan_o) |-> $past(seq_acc, 6));

    // R9: outputs hold between result pulses
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(d_o) && $stable(q_o)));
endmodule

// File: tb/abcdq_xform_tb.sv
`timescale 1ns/1ps
module abcdq_xform_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] sin_i = '0, cos_i = '0;
    logic [15:0] vlt_a_i = '0, vlt_b_i = '0, vlt_c_i = '0;
    logic [15:0] cur_a_i = '0, cur_b_i = '0, cur_c_i = '0;
    logic        done_o, chan_o;
    logic [15:0] d_o, q_o;

    int errs = 0;
    int nchk = 0;
    int cyc  = 0;
    bit finished = 0;

    int     ev_n = 0;
    int     ev_cyc [8];
    bit     ev_ch  [8];
    longint ev_d   [8];
    longint ev_q   [8];

    abcdq_xform dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sin_i(sin_i), .cos_i(cos_i),
        .vlt_a_i(vlt_a_i), .vlt_b_i(vlt_b_i), .vlt_c_i(vlt_c_i),
        .cur_a_i(cur_a_i), .cur_b_i(cur_b_i), .cur_c_i(cur_c_i),
        .done_o(done_o), .chan_o(chan_o), .d_o(d_o), .q_o(q_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            errs++;
            nchk++;
            $display("FAIL watchdog: expired at cycle %0d, expected end before 100000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (done_o && ev_n < 8) begin
            ev_cyc[ev_n] = cyc;
            ev_ch[ev_n]  = chan_o;
            ev_d[ev_n]   = longint'($signed(d_o));
            ev_q[ev_n]   = longint'($signed(q_o));
            ev_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clip16(input longint v, output bit sat);
        sat = 1'b1;
        if (v > 32767)       return 32767;
        else if (v < -32768) return -32768;
        sat = 1'b0;
        return v;
    endfunction

    // Expected results straight from the R2..R5 arithmetic
    task automatic model(input longint a, b, c, s, k,
                         output longint d, q, output bit sat);
        longint hc, hs, ks, kc, sd, sq;
        bit s1, s2;
        hc = k >>> 1;
        hs = s >>> 1;
        ks = (28378 * s) >>> 15;
        kc = (28378 * k) >>> 15;
        sd = a * k + b * (-hc + ks) + c * (-hc - ks);
        sq = a * s + b * (-hs - kc) + c * (-hs + kc);
        d = clip16((((sd >>> 15) * 26755) >>> 15), s1);
        q = clip16((((sq >>> 15) * 26755) >>> 15), s2);
        sat = s1 | s2;
    endtask

    task automatic drive(input int s, k, va, vb, vc, ia, ib, ic);
        sin_i = 16'(s);   cos_i = 16'(k);
        vlt_a_i = 16'(va); vlt_b_i = 16'(vb); vlt_c_i = 16'(vc);
        cur_a_i = 16'(ia); cur_b_i = 16'(ib); cur_c_i = 16'(ic);
    endtask

    task automatic check_set(input int idx, input int expcyc, input bit expch,
                             input longint ed, eq, input bit sat);
        string tg;
        tg = sat ? "R5 clip" : "R3/R4 value";
        chk(ev_cyc[idx] == expcyc, "R6 result cycle", ev_cyc[idx], expcyc);
        chk(ev_ch[idx] == expch, "R6 set tag", ev_ch[idx], expch);
        chk(ev_d[idx] == ed, {"R2 R3 d ", tg}, ev_d[idx], ed);
        chk(ev_q[idx] == eq, {"R2 R4 q ", tg}, ev_q[idx], eq);
    endtask

    // One job; inputs are scrambled right after the start cycle (R7)
    task automatic run_job(input int s, k, va, vb, vc, ia, ib, ic);
        longint d0, q0, d1, q1;
        bit sa0, sa1;
        int c0;
        model(va, vb, vc, s, k, d0, q0, sa0);
        model(ia, ib, ic, s, k, d1, q1, sa1);
        @(negedge clk);
        drive(s, k, va, vb, vc, ia, ib, ic);
        start_i = 1'b1;
        ev_n = 0;
        c0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        drive(~s, k ^ 16'h1234, vc + 77, va - 5, vb ^ 3, ic, ia + 9, ib - 1);
        repeat (8) @(negedge clk);
        chk(ev_n == 2, "R6 two results per job", ev_n, 2);
        check_set(0, c0 + 6, 1'b0, d0, q0, sa0);
        check_set(1, c0 + 7, 1'b1, d1, q1, sa1);
        chk(longint'($signed(d_o)) == d1, "R9 d hold", longint'($signed(d_o)), d1);
        chk(longint'($signed(q_o)) == q1, "R9 q hold", longint'($signed(q_o)), q1);
    endtask

    int lcg = 32'h1ACE5;
    function automatic int rnd16();
        lcg = lcg * 1103515245 + 12345;
        return int'($signed(lcg[23:8]));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
        chk(d_o == 16'd0, "R1 d after reset", d_o, 0);
        chk(q_o == 16'd0, "R1 q after reset", q_o, 0);

        // Angle sweep with several input patterns
        for (int k = 0; k < 24; k++) begin
            real th;
            int s, c;
            th = 2.0 * 3.14159265358979 * k / 24.0;
            s = int'(32767.0 * $sin(th));
            c = int'(32767.0 * $cos(th));
            run_job(s, c,
                    int'(20000.0 * $cos(th + 0.3)),
                    int'(20000.0 * $cos(th + 0.3 - 2.0943951)),
                    int'(20000.0 * $cos(th + 0.3 + 2.0943951)),
                    int'(12000.0 * $cos(th - 0.5)),
                    int'(12000.0 * $cos(th - 0.5 - 2.0943951)),
                    int'(12000.0 * $cos(th - 0.5 + 2.0943951)));
            run_job(s, c, k * 997 - 15000, 0, 0, 0, 23000 - k * 1500, 0);
            run_job(s, c, 32767, -32768, -32768, -32768, 32767, 32767);
            run_job(s, c, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16());
        end
        // Extreme angle codes
        run_job(-32768, 0, 32767, -32768, -32768, -32768, 32767, 32767);
        run_job(0, -32768, 32767, 32767, -32768, 1, -1, 0);

        // R8: start held three cycles, only the first is taken
        begin
            longint d0, q0, d1, q1;
            bit sa0, sa1;
            int c0;
            model(1000, 2000, -3000, 11585, 30000, d0, q0, sa0);
            model(-4000, 500, 3500, 11585, 30000, d1, q1, sa1);
            @(negedge clk);
            drive(11585, 30000, 1000, 2000, -3000, -4000, 500, 3500);
            start_i = 1'b1; ev_n = 0; c0 = cyc;
            @(negedge clk);
            drive(-20000, 5000, 9999, 9999, 9999, 9999, 9999, 9999);
            @(negedge clk);
            drive(3000, -3000, -7777, 1, 2, 3, 4, 5);
            @(negedge clk);
            start_i = 1'b0;
            repeat (10) @(negedge clk);
            chk(ev_n == 2, "R8 repeated start ignored", ev_n, 2);
            check_set(0, c0 + 6, 1'b0, d0, q0, sa0);
            check_set(1, c0 + 7, 1'b1, d1, q1, sa1);
        end

        // R8: start three cycles later is accepted
        begin
            longint da, qa, db, qb, dc, qc, dd, qd;
            bit sx;
            int c0;
            model(15000, -5000, -10000, 23170, 23170, da, qa, sx);
            model(100, 200, 300, 23170, 23170, db, qb, sx);
            model(-8000, 16000, -8000, -23170, 23170, dc, qc, sx);
            model(3000, 3000, -6000, -23170, 23170, dd, qd, sx);
            @(negedge clk);
            drive(23170, 23170, 15000, -5000, -10000, 100, 200, 300);
            start_i = 1'b1; ev_n = 0; c0 = cyc;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
            drive(-23170, 23170, -8000, 16000, -8000, 3000, 3000, -6000);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (10) @(negedge clk);
            chk(ev_n == 4, "R8 back-to-back results", ev_n, 4);
            check_set(0, c0 + 6, 1'b0, da, qa, 1'b0);
            check_set(1, c0 + 7, 1'b1, db, qb, 1'b0);
            check_set(2, c0 + 9, 1'b0, dc, qc, 1'b0);
            check_set(3, c0 + 10, 1'b1, dd, qd, 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule